// File: doc/BRIEF.md
# Background LMS Correction Engine for a Pipelined Converter

This block turns the raw stage decisions of a fast pipelined converter into a corrected output code. It does this on every clock, as a weighted sum of ternary stage decisions. A slower but more accurate reference converter samples the same analog input at a decimated rate. Each time it delivers a code, the engine compares that code with its own correction of the matching fast sample, which it keeps in a short delay line. It then nudges every weight along the gradient of the squared error, using a least-mean-squares step.

Adaptation runs alongside conversion and never stalls the full-rate output. The step size is a power of two selected by a shift amount, so the update needs only shifts and adders. Weights are signed fixed-point values that carry `FRAC` bits below the output LSB. They saturate instead of wrapping. A synchronous reset loads the ideal binary weights, so the block starts as an uncalibrated but working converter back end.

Top module: `lms_bg_cal`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `corr_o` = 0 and every weight at its nominal value. For stage i, that value is 2^(NSTG-1-i+FRAC). Stage 0 is the most significant stage. Reset also clears the decision delay line to all-zero decisions.
- R2: Each stage decision is a 2-bit code in `dec_i[2i+1:2i]`. Code 01 means +1, code 11 means -1, and codes 00 and 10 both mean 0.
- R3: One cycle after `dec_i` is presented, `corr_o` equals floor(sum over i of w_i*d_i / 2^FRAC), computed with the weights held in that earlier cycle. This happens every cycle, whatever the state of `ref_valid_i` and `adapt_en_i`.
- R4: The weights change only in a cycle where `ref_valid_i` and `adapt_en_i` are both high. In any other cycle, `weights_o` stays unchanged.
- R5: The error is e = `ref_code_i`*2^FRAC - sum over i of w_i*dd_i. Here dd_i are the delayed decisions and w_i are the weights from before the update.
- R6: On an update, each weight becomes w_i + dd_i*floor(e / 2^`mu_shift_i`). A stage whose delayed decision is 0 keeps its weight.
- R7: An updated weight that falls outside the signed WW-bit range is clamped to 2^(WW-1)-1 or to -2^(WW-1).
- R8: The decisions paired with a reference code are those presented on `dec_i` exactly REF_LAT cycles before that code's `ref_valid_i` cycle.
- R9: Updated weights take part in the correction computed in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the fast sample rate |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_i | input | 2*NSTG | Raw ternary decisions, 2 bits per stage, stage 0 in the low bits |
| ref_valid_i | input | 1 | Strobe marking a reference code |
| ref_code_i | input | REF_W | Signed reference code |
| adapt_en_i | input | 1 | Allows weight adaptation |
| mu_shift_i | input | 4 | Step size as a right shift: mu = 2^-mu_shift_i |
| corr_o | output | WW+clog2(NSTG)+1-FRAC | Signed corrected output code |
| weights_o | output | NSTG*WW | Current weights, stage i in bits [i*WW +: WW] |

## Verification
A wrong weight shows up on `corr_o` in the very next cycle for any input whose decision for that stage is nonzero. It is also visible directly on `weights_o` one cycle after the faulty update. A misaligned delay line leaves the weights correct until the first reference strobe. From then on, the wrong stages move, or stages that should not move do, and the bench catches this on the cycle after that strobe. Saturation, freeze and ignored codes each show as a weight that differs from the model right after the cycle that should have left it in place or clamped it.

// File: rtl/lms_cal_pkg.sv
package lms_cal_pkg;

    // Ternary stage decision: 01 -> +1, 11 -> -1, 00/10 -> 0
    function automatic logic signed [1:0] tern(input logic [1:0] code);
        logic signed [1:0] v;
        case (code)
            2'b01:   v = 2'sb01;
            2'b11:   v = 2'sb11;
            default: v = 2'sb00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lms_dec_delay.sv
module lms_dec_delay #(
    parameter int W     = 22,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [DEPTH];
    logic [W-1:0] stg_q [DEPTH];

    always_comb begin
        stg_d[0] = d_i;
        for (int k = 1; k < DEPTH; k++) stg_d[k] = stg_q[k-1];
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) stg_d[k] = '0;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) stg_q[k] <= stg_d[k];
    end

    assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/lms_dot.sv
module lms_dot #(
    parameter int NSTG = 11,
    parameter int WW   = 22,
    parameter int SW   = 27
) (
    input  logic [2*NSTG-1:0]     dec_i,
    input  logic [NSTG*WW-1:0]    w_i,
    output logic signed [SW-1:0]  sum_o
);
    import lms_cal_pkg::*;

    always_comb begin
        logic signed [SW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NSTG; i++) begin
            case (tern(dec_i[2*i +: 2]))
                2'sb01:  acc = acc + SW'($signed(w_i[i*WW +: WW]));
                2'sb11:  acc = acc - SW'($signed(w_i[i*WW +: WW]));
                default: acc = acc;
            endcase
        end
        sum_o = acc;
    end
endmodule

// File: rtl/lms_upd.sv
module lms_upd #(
    parameter int NSTG = 11,
    parameter int WW   = 22,
    parameter int EW   = 28
) (
    input  logic [NSTG*WW-1:0]   w_i,
    input  logic [2*NSTG-1:0]    dec_i,
    input  logic signed [EW-1:0] delta_i,
    output logic [NSTG*WW-1:0]   w_o
);
    import lms_cal_pkg::*;

    localparam int CW = EW + 2;
    localparam logic signed [CW-1:0] WMAX = {{(CW-WW+1){1'b0}}, {(WW-1){1'b1}}};
    localparam logic signed [CW-1:0] WMIN = {{(CW-WW+1){1'b1}}, {(WW-1){1'b0}}};

    for (genvar i = 0; i < NSTG; i++) begin : g_stage
        logic signed [CW-1:0] cand;
        logic [WW-1:0]        res;

        always_comb begin
            logic signed [CW-1:0] wx;
            logic signed [CW-1:0] dx;
            wx = CW'($signed(w_i[i*WW +: WW]));
            dx = CW'(delta_i);
            case (tern(dec_i[2*i +: 2]))
                2'sb01:  cand = wx + dx;
                2'sb11:  cand = wx - dx;
                default: cand = wx;
            endcase
            if (cand > WMAX)      res = WMAX[WW-1:0];
            else if (cand < WMIN) res = WMIN[WW-1:0];
            else                  res = cand[WW-1:0];
        end

        assign w_o[i*WW +: WW] = res;
    end
endmodule

// File: rtl/lms_bg_cal.sv
module lms_bg_cal #(
    parameter int NSTG    = 11,
    parameter int FRAC    = 8,
    parameter int WW      = 22,
    parameter int REF_W   = 16,
    parameter int REF_LAT = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [2*NSTG-1:0]                       dec_i,
    input  logic                                    ref_valid_i,
    input  logic signed [REF_W-1:0]                 ref_code_i,
    input  logic                                    adapt_en_i,
    input  logic [3:0]                              mu_shift_i,
    output logic signed [WW+$clog2(NSTG)+1-FRAC-1:0] corr_o,
    output logic [NSTG*WW-1:0]                      weights_o
);
    localparam int DW    = 2 * NSTG;
    localparam int SW    = WW + $clog2(NSTG) + 1;
    localparam int OUT_W = SW - FRAC;
    localparam int EW    = ((SW > REF_W + FRAC) ? SW : REF_W + FRAC) + 1;

    typedef struct packed {
        logic signed [OUT_W-1:0] corr;
        logic [NSTG*WW-1:0]      w;
    } cal_st_t;

    cal_st_t st_d, st_q;

    logic [NSTG*WW-1:0]   w_nom;
    logic [NSTG*WW-1:0]   w_upd;
    logic [DW-1:0]        dly_last;
    logic signed [SW-1:0] sum_now;
    logic signed [SW-1:0] sum_dly;
    logic signed [EW-1:0] err;
    logic signed [EW-1:0] delta;

    for (genvar i = 0; i < NSTG; i++) begin : g_nom
        assign w_nom[i*WW +: WW] = WW'(1) << (NSTG - 1 - i + FRAC);
    end

    lms_dec_delay #(.W(DW), .DEPTH(REF_LAT)) i_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dec_i),
        .q_o   (dly_last)
    );

    lms_dot #(.NSTG(NSTG), .WW(WW), .SW(SW)) i_dot_now (
        .dec_i (dec_i),
        .w_i   (st_q.w),
        .sum_o (sum_now)
    );

    lms_dot #(.NSTG(NSTG), .WW(WW), .SW(SW)) i_dot_dly (
        .dec_i (dly_last),
        .w_i   (st_q.w),
        .sum_o (sum_dly)
    );

    always_comb begin
        logic signed [EW-1:0] ref_fx;
        ref_fx = EW'(ref_code_i) <<< FRAC;
        err    = ref_fx - EW'(sum_dly);
        delta  = err >>> mu_shift_i;
    end

    lms_upd #(.NSTG(NSTG), .WW(WW), .EW(EW)) i_upd (
        .w_i     (st_q.w),
        .dec_i   (dly_last),
        .delta_i (delta),
        .w_o     (w_upd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.corr = sum_now[SW-1:FRAC];
        if (ref_valid_i && adapt_en_i) st_d.w = w_upd;
        if (!rst_n) begin
            st_d.corr = '0;
            st_d.w    = w_nom;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign corr_o    = st_q.corr;
    assign weights_o = st_q.w;
endmodule

// File: rtl/lms_bg_cal_chk.sv
module lms_bg_cal_chk #(
    parameter int NSTG  = 11,
    parameter int FRAC  = 8,
    parameter int WW    = 22,
    parameter int OUT_W = 19
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2*NSTG-1:0]       dec_i,
    input logic                    ref_valid_i,
    input logic                    adapt_en_i,
    input logic signed [OUT_W-1:0] corr_o,
    input logic [NSTG*WW-1:0]      weights_o,
    input logic [2*NSTG-1:0]       dly_last
);
    logic dec_all_zero;

    always_comb begin
        dec_all_zero = 1'b1;
        for (int i = 0; i < NSTG; i++) begin
            if (dec_i[2*i]) dec_all_zero = 1'b0;
        end
    end

    // R4
    weights_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_valid_i && adapt_en_i) |=> $stable(weights_o));

    // R2
    zero_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_all_zero |=> (corr_o == '0));

    for (genvar i = 0; i < NSTG; i++) begin : g_stage_chk
        // R1
        nominal_reset_chk: assert property (@(posedge clk)
            !rst_n |=> (weights_o[i*WW +: WW] == (WW'(1) << (NSTG - 1 - i + FRAC))));

        // R6
        idle_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dly_last[2*i] |=> $stable(weights_o[i*WW +: WW]));
    end
endmodule

bind lms_bg_cal lms_bg_cal_chk #(
    .NSTG  (NSTG),
    .FRAC  (FRAC),
    .WW    (WW),
    .OUT_W (OUT_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_i       (dec_i),
    .ref_valid_i (ref_valid_i),
    .adapt_en_i  (adapt_en_i),
    .corr_o      (corr_o),
    .weights_o   (weights_o),
    .dly_last    (dly_last)
);

// File: tb/test_lms_bg_cal.sv
module test_lms_bg_cal;
    localparam int  NSTG       = 11;
    localparam int  FRAC       = 8;
    localparam int  WW         = 22;
    localparam int  REF_W      = 16;
    localparam int  REF_LAT    = 4;
    localparam int  SW         = WW + $clog2(NSTG) + 1;
    localparam int  OUT_W      = SW - FRAC;
    localparam int  DW         = 2 * NSTG;
    localparam time CLK_PERIOD = 10ns;
    localparam longint WMAXL   = (64'sd1 <<< (WW - 1)) - 1;
    localparam longint WMINL   = -(64'sd1 <<< (WW - 1));

    // {adapt_en, ref_valid, mu_shift, ref_code, decisions}
    localparam int NVEC = 14;
    localparam logic [43:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 4'd2, 16'd0,     22'b01_00_11_01_00_01_11_00_01_01_11},
        {1'b1, 1'b0, 4'd2, 16'd0,     22'b11_01_01_00_10_11_01_01_00_11_01},
        {1'b1, 1'b0, 4'd2, 16'd0,     22'b01_01_01_01_01_01_01_01_01_01_01},
        {1'b1, 1'b0, 4'd2, 16'd0,     22'b11_11_11_11_11_11_11_11_11_11_11},
        {1'b1, 1'b1, 4'd3, 16'd1000,  22'b00_01_11_01_01_00_11_01_10_01_00},
        {1'b1, 1'b1, 4'd2, 16'hFC7C,  22'b01_11_00_11_01_01_00_11_01_00_11},
        {1'b1, 1'b1, 4'd4, 16'd1500,  22'b01_00_01_10_11_01_00_01_11_01_01},
        {1'b0, 1'b1, 4'd1, 16'd2000,  22'b11_01_00_01_01_11_01_00_01_11_00},
        {1'b1, 1'b1, 4'd0, 16'd77,    22'b10_10_01_11_00_01_01_11_01_00_01},
        {1'b1, 1'b0, 4'd0, 16'd3000,  22'b01_11_01_11_01_11_01_11_01_11_01},
        {1'b1, 1'b1, 4'd5, 16'hF000,  22'b00_00_01_01_11_11_00_00_01_01_11},
        {1'b1, 1'b1, 4'd15, 16'd20,   22'b01_01_00_00_11_11_01_01_00_00_11},
        {1'b0, 1'b0, 4'd2, 16'd500,   22'b11_00_01_11_00_01_11_00_01_11_00},
        {1'b1, 1'b1, 4'd1, 16'd250,   22'b01_10_11_00_01_10_11_00_01_10_11}
    };

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [DW-1:0]           dec_i;
    logic                    ref_valid_i;
    logic signed [REF_W-1:0] ref_code_i;
    logic                    adapt_en_i;
    logic [3:0]              mu_shift_i;
    logic signed [OUT_W-1:0] corr_o;
    logic [NSTG*WW-1:0]      weights_o;

    int     n_vec = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    longint wm [NSTG];
    logic [DW-1:0] hist [REF_LAT];

    always #(CLK_PERIOD/2) clk = ~clk;

    lms_bg_cal #(
        .NSTG(NSTG), .FRAC(FRAC), .WW(WW), .REF_W(REF_W), .REF_LAT(REF_LAT)
    ) i_lms_bg_cal (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_i       (dec_i),
        .ref_valid_i (ref_valid_i),
        .ref_code_i  (ref_code_i),
        .adapt_en_i  (adapt_en_i),
        .mu_shift_i  (mu_shift_i),
        .corr_o      (corr_o),
        .weights_o   (weights_o)
    );

    function automatic longint dval(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    function automatic longint sat(input longint v);
        if (v > WMAXL) return WMAXL;
        if (v < WMINL) return WMINL;
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NSTG; i++) wm[i] = 64'sd1 <<< (NSTG - 1 - i + FRAC);
        for (int k = 0; k < REF_LAT; k++) hist[k] = '0;
    endtask

    task automatic check_weights(input string tag);
        n_vec++;
        for (int i = 0; i < NSTG; i++) begin
            longint got;
            got = longint'($signed(weights_o[i*WW +: WW]));
            if (got !== wm[i]) begin
                n_bad++;
                $display("FAIL %s weight %0d: actual %0d expected %0d", tag, i, got, wm[i]);
                break;
            end
        end
    endtask

    task automatic check_corr(input longint exp_c, input string tag);
        n_vec++;
        if (longint'(corr_o) !== exp_c) begin
            n_bad++;
            $display("FAIL %s corr_o: actual %0d expected %0d", tag, longint'(corr_o), exp_c);
        end
    endtask

    // One sample: drive, model, then compare after the edge
    task automatic step(input logic [DW-1:0] d, input logic rv, input logic [15:0] rc,
                        input logic en, input logic [3:0] sh, input string tag);
        longint s_now, s_dly, e, dl, exp_c;
        @(negedge clk);
        dec_i = d; ref_valid_i = rv; ref_code_i = rc; adapt_en_i = en; mu_shift_i = sh;
        s_now = 0; s_dly = 0;
        for (int i = 0; i < NSTG; i++) begin
            s_now += wm[i] * dval(d[2*i +: 2]);
            s_dly += wm[i] * dval(hist[REF_LAT-1][2*i +: 2]);
        end
        exp_c = s_now >>> FRAC;
        if (rv && en) begin
            e  = (longint'($signed(rc)) <<< FRAC) - s_dly;
            dl = e >>> sh;
            for (int i = 0; i < NSTG; i++)
                wm[i] = sat(wm[i] + dval(hist[REF_LAT-1][2*i +: 2]) * dl);
        end
        for (int k = REF_LAT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = d;
        @(posedge clk);
        #1;
        check_corr(exp_c, "R3");
        check_weights(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dec_i = '1; ref_valid_i = 1'b1; adapt_en_i = 1'b1;
        ref_code_i = 16'sd100; mu_shift_i = 4'd0;
        model_reset();
        @(posedge clk);
        #1;
        check_corr(0, "R1");
        check_weights("R1");
        @(negedge clk);
        rst_n = 1'b1; ref_valid_i = 1'b0; dec_i = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dec_i = '0; ref_valid_i = 1'b0; ref_code_i = '0;
        adapt_en_i = 1'b0; mu_shift_i = '0;
        model_reset();
        do_reset();

        // Table walk: R5, R6, R8 and R4 (entries with adapt_en low)
        for (int v = 0; v < NVEC; v++)
            step(VEC[v][21:0], VEC[v][42], VEC[v][37:22], VEC[v][43], VEC[v][41:38], "R5/R6");

        // R2: codes 10 and 00 contribute nothing
        do_reset();
        step({NSTG{2'b10}}, 1'b0, 16'd0, 1'b1, 4'd0, "R2");
        step({NSTG{2'b00}}, 1'b0, 16'd0, 1'b1, 4'd0, "R2");

        // R8: a single +1 on stage 0 pairs with the strobe REF_LAT cycles later
        do_reset();
        step(22'b00_00_00_00_00_00_00_00_00_00_01, 1'b0, 16'd0, 1'b1, 4'd1, "R8");
        for (int k = 1; k < REF_LAT; k++)
            step('0, 1'b0, 16'd0, 1'b1, 4'd1, "R8");
        step('0, 1'b1, 16'd0, 1'b1, 4'd1, "R8");
        if (wm[0] != (64'sd1 <<< (NSTG - 1 + FRAC - 1)))
            $display("note: model weight 0 = %0d", wm[0]);

        // R9: the updated weight shows on the correction of the next sample
        step(22'b00_00_00_00_00_00_00_00_00_00_01, 1'b0, 16'd0, 1'b1, 4'd0, "R9");

        // R4: strobe with adaptation disabled leaves every weight alone
        for (int k = 0; k < REF_LAT + 2; k++)
            step({NSTG{2'b01}}, 1'b1, 16'd9000, 1'b0, 4'd0, "R4");

        // R7: drive stage 0 to the positive, then the negative limit
        do_reset();
        for (int k = 0; k < REF_LAT + 4; k++)
            step(22'b00_00_00_00_00_00_00_00_00_00_01, 1'b1, 16'h7FFF, 1'b1, 4'd0, "R7");
        for (int k = 0; k < REF_LAT + 4; k++)
            step(22'b00_00_00_00_00_00_00_00_00_00_01, 1'b1, 16'h8000, 1'b1, 4'd0, "R7");
        for (int k = 0; k < REF_LAT + 4; k++)
            step(22'b00_00_00_00_00_00_00_00_00_00_11, 1'b1, 16'h8000, 1'b1, 4'd0, "R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule